// File: doc/BRIEF.md
# Dual-Core Machine Timer

This block is a 64-bit machine timer that two processor cores share. It has one free-running counter and a compare register for each core. Each core has its own level-sensitive timer interrupt, which is raised while the counter has reached or passed that core's compare value. Software works through a single-cycle 32-bit register port. Each access carries the ID of the core that makes it, and that ID picks which core's compare register the compare offsets reach. The counter offsets reach the one shared counter whatever the ID.

A control word starts and stops counting and chooses the rate. In full-speed mode the counter steps on every clock. In tick mode it steps only on clocks where the external tick input is high. Reads are registered: read data and its valid flag appear one clock after the request, and they carry the state as it stood at the sampling edge.

Top module: `dual_core_mtimer`

## Requirements
- R1: After reset the counter is zero, both control bits are clear, both compare registers hold all ones, and both interrupt outputs are low.
- R2: The byte offsets are: control 0x00, counter low 0x04, counter high 0x08, compare low 0x0C, compare high 0x10. Control bit 0 is enable and bit 1 is full-speed. A read of any other offset returns zero, and a write to one changes nothing.
- R3: While enable is clear the counter holds its value.
- R4: While enable and full-speed are both set the counter grows by one on every clock.
- R5: While enable is set and full-speed is clear, the counter grows by one only on clocks where the tick input is high.
- R6: A counter write from either core ID changes the value that both core IDs read.
- R7: A compare access with core ID n reads or writes only core n's compare register.
- R8: Interrupt n is a level that goes high one clock after the counter becomes greater than or equal to compare register n, and it follows that relation whatever the state of enable.
- R9: A write to one 32-bit half of the counter replaces that half only. The other half keeps its value, with no carry or borrow into it.
- R10: When the running counter steps past all ones in its low half, the high half increments on the same clock.
- R11: A counter write in a clock where an increment would also happen takes priority, and the written value appears with no increment added.
- R12: A read returns its data, with the valid flag high, one clock after the request. The data shows the state from before that edge's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Count pulse used in tick mode |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_core | input | 1 | ID of the accessing core |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one clock after a read |
| bus_rdata | output | 32 | Read data |
| irq | output | 2 | Per-core timer interrupt levels |

## Verification
The hardest case to reach from the ports is the low-to-high carry while the counter runs. The bench stops the counter, loads the value 0x5_FFFFFFFE a half at a time, restarts at full speed, and reads the halves on successive clocks so that the reads fall on the edge where the carry happens. Write priority over a live increment is reached the same way. A low-half write lands on a running counter, and the reads that follow must show the written value and then that value plus one. The interrupt latency is checked on each side of its edge by sampling the levels one and two clocks after the counter write.

// File: rtl/mtmr_pkg.sv
// Shared offsets, control bit positions and decode types of the machine timer.
package mtmr_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CMP_LO = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CMP_HI = 5'h10;

    localparam int BIT_EN = 0;
    localparam int BIT_FS = 1;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_CTRL,
        SRC_CNT_LO,
        SRC_CNT_HI,
        SRC_CMP_LO,
        SRC_CMP_HI
    } rd_src_e;

    typedef struct packed {
        logic ctrl;
        logic cnt_lo;
        logic cnt_hi;
        logic cmp_lo;
        logic cmp_hi;
    } wr_stb_t;
endpackage

// File: rtl/mtmr_decode.sv
// Address decode of the timer's register port.
// Turns one access into a register selector and per-register write strobes.
// Assumes: the offset is compared in full, and anything unmapped selects nothing.
module mtmr_decode
    import mtmr_pkg::*;
(
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output rd_src_e           src,
    output wr_stb_t           wr
);
    // Map the offset to the register it names.
    always_comb begin
        unique case (addr)
            OFS_CTRL:   src = SRC_CTRL;
            OFS_CNT_LO: src = SRC_CNT_LO;
            OFS_CNT_HI: src = SRC_CNT_HI;
            OFS_CMP_LO: src = SRC_CMP_LO;
            OFS_CMP_HI: src = SRC_CMP_HI;
            default:    src = SRC_NONE;
        endcase
    end

    // Raise the write strobe of the selected register on a write access.
    always_comb begin
        wr        = '0;
        wr.ctrl   = sel && we && (src == SRC_CTRL);
        wr.cnt_lo = sel && we && (src == SRC_CNT_LO);
        wr.cnt_hi = sel && we && (src == SRC_CNT_HI);
        wr.cmp_lo = sel && we && (src == SRC_CMP_LO);
        wr.cmp_hi = sel && we && (src == SRC_CMP_HI);
    end
endmodule

// File: rtl/mtmr_counter.sv
// Shared 64-bit time counter.
// A write to either half replaces that half only, and a write beats that cycle's step.
// Assumes: at most one half is written per cycle, since the port carries one access.
module mtmr_counter #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                step,
    output logic [2*DATA_W-1:0] cnt
);
    localparam int CNT_W = 2 * DATA_W;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Load a half, or advance the full width so the carry reaches the high half at once.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (wr_lo)
            cnt[DATA_W-1:0] <= wdata;
        else if (wr_hi)
            cnt[CNT_W-1:DATA_W] <= wdata;
        else if (step)
            cnt <= cnt + ONE;
    end
endmodule

// File: rtl/mtmr_cmp_slot.sv
// One core's compare register and its registered interrupt level.
// Assumes: the strobes are already qualified by the core ID, and the reset
// value of all ones keeps the interrupt low until software programs it.
module mtmr_cmp_slot #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [2*DATA_W-1:0] cnt,
    output logic [2*DATA_W-1:0] cmp,
    output logic                irq
);
    localparam int CNT_W = 2 * DATA_W;

    // Hold the compare value and replace one half per write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp <= '1;
        else if (wr_lo)
            cmp[DATA_W-1:0] <= wdata;
        else if (wr_hi)
            cmp[CNT_W-1:DATA_W] <= wdata;
    end

    // Register the reached-or-passed comparison as the interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= (cnt >= cmp);
    end
endmodule

// File: rtl/dual_core_mtimer.sv
// Machine timer for several cores: one shared counter, one compare slot per core.
// Holds the control bits and builds the step enable, then returns a registered read.
// Assumes: bus_core stays below NUM_CORES, and an out-of-range ID reads compare as zero.
module dual_core_mtimer
    import mtmr_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_CORES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic                 bus_core,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic                 bus_rvalid,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_CORES-1:0] irq
);
    localparam int CNT_W = 2 * DATA_W;

    rd_src_e                         src;
    wr_stb_t                         wr;
    logic                            ctl_en;
    logic                            ctl_fs;
    logic                            step;
    logic [CNT_W-1:0]                cnt;
    logic [NUM_CORES-1:0][CNT_W-1:0] cmp_vec;
    logic [NUM_CORES-1:0]            own;
    logic [CNT_W-1:0]                cmp_sel;
    logic [DATA_W-1:0]               rd_mux;

    mtmr_decode u_dec (
        .sel  (bus_sel),
        .we   (bus_we),
        .addr (bus_addr),
        .src  (src),
        .wr   (wr)
    );

    // Keep the enable and full-speed control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en <= 1'b0;
            ctl_fs <= 1'b0;
        end else if (wr.ctrl) begin
            ctl_en <= bus_wdata[BIT_EN];
            ctl_fs <= bus_wdata[BIT_FS];
        end
    end

    // Step on every clock at full speed, or only on tick clocks otherwise.
    assign step = ctl_en && (ctl_fs || tick_i);

    mtmr_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (wr.cnt_lo),
        .wr_hi (wr.cnt_hi),
        .wdata (bus_wdata),
        .step  (step),
        .cnt   (cnt)
    );

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_slot
        assign own[g] = (32'(bus_core) == g);

        mtmr_cmp_slot #(.DATA_W(DATA_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_lo (wr.cmp_lo && own[g]),
            .wr_hi (wr.cmp_hi && own[g]),
            .wdata (bus_wdata),
            .cnt   (cnt),
            .cmp   (cmp_vec[g]),
            .irq   (irq[g])
        );
    end

    // Pick the accessing core's compare value.
    always_comb begin
        cmp_sel = '0;
        for (int i = 0; i < NUM_CORES; i++)
            if (own[i]) cmp_sel = cmp_vec[i];
    end

    // Select the word that a read returns.
    always_comb begin
        unique case (src)
            SRC_CTRL: begin
                rd_mux         = '0;
                rd_mux[BIT_EN] = ctl_en;
                rd_mux[BIT_FS] = ctl_fs;
            end
            SRC_CNT_LO: rd_mux = cnt[DATA_W-1:0];
            SRC_CNT_HI: rd_mux = cnt[CNT_W-1:DATA_W];
            SRC_CMP_LO: rd_mux = cmp_sel[DATA_W-1:0];
            SRC_CMP_HI: rd_mux = cmp_sel[CNT_W-1:DATA_W];
            default:    rd_mux = '0;
        endcase
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_sel && !bus_we;
            bus_rdata  <= (bus_sel && !bus_we) ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/mtmr_checker.sv
// Properties of the machine timer, attached to the top through bind.
module mtmr_checker #(
    parameter int DATA_W    = 32,
    parameter int NUM_CORES = 2
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                tick_i,
    input logic                                bus_core,
    input logic [DATA_W-1:0]                   bus_wdata,
    input logic                                ctl_en,
    input logic                                ctl_fs,
    input logic                                wr_cnt_lo,
    input logic                                wr_cnt_hi,
    input logic                                wr_cmp_lo,
    input logic                                wr_cmp_hi,
    input logic [2*DATA_W-1:0]                 cnt,
    input logic [NUM_CORES-1:0][2*DATA_W-1:0]  cmp_vec,
    input logic [NUM_CORES-1:0]                irq
);
    localparam int CNT_W = 2 * DATA_W;
    logic cnt_wr;
    assign cnt_wr = wr_cnt_lo || wr_cnt_hi;

    assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !cnt_wr) |=> $stable(cnt));

    assert_full_speed_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_en && ctl_fs && !cnt_wr) |=> (cnt == $past(cnt) + 1'b1));

    assert_tick_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_en && !ctl_fs && !tick_i && !cnt_wr) |=> $stable(cnt));

    assert_lo_write_keeps_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_lo |=> (cnt[CNT_W-1:DATA_W] == $past(cnt[CNT_W-1:DATA_W])));

    assert_hi_write_keeps_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_hi |=> (cnt[DATA_W-1:0] == $past(cnt[DATA_W-1:0])));

    assert_write_beats_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_lo |=> (cnt[DATA_W-1:0] == $past(bus_wdata)));

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq[g] == ($past(cnt) >= $past(cmp_vec[g]))));

        assert_own_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ((wr_cmp_lo || wr_cmp_hi) && (32'(bus_core) != g)) |=> $stable(cmp_vec[g]));
    end
endmodule

bind dual_core_mtimer mtmr_checker #(.DATA_W(DATA_W), .NUM_CORES(NUM_CORES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .bus_core  (bus_core),
    .bus_wdata (bus_wdata),
    .ctl_en    (ctl_en),
    .ctl_fs    (ctl_fs),
    .wr_cnt_lo (wr.cnt_lo),
    .wr_cnt_hi (wr.cnt_hi),
    .wr_cmp_lo (wr.cmp_lo),
    .wr_cmp_hi (wr.cmp_hi),
    .cnt       (cnt),
    .cmp_vec   (cmp_vec),
    .irq       (irq)
);

// File: tb/dual_core_mtimer_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected read data, and the monitor compares the returns.
module dual_core_mtimer_test;
    localparam real CLK_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_core = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int total = 0;
    int fails = 0;
    bit done = 0;

    typedef struct { string tag; logic [31:0] exp; } item_t;
    item_t exp_q[$];

    dual_core_mtimer uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_core(bus_core), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_NS / 2.0) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic core, input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_core = core; bus_addr = a; bus_wdata = d; tick_i = 0;
    endtask

    task automatic rd(input logic core, input logic [4:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_core = core; bus_addr = a; tick_i = 0;
        exp_q.push_back('{tag, e});
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            bus_sel = 0; bus_we = 0; tick_i = 0;
        end
    endtask

    task automatic pulse();
        @(negedge clk);
        bus_sel = 0; bus_we = 0; tick_i = 1;
    endtask

    // Monitor: match each read return with the oldest queued item.
    always @(posedge clk) begin
        #2;
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) check("R12 unexpected read return", 32'd1, 32'd0);
            else begin
                item_t it;
                it = exp_q.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 irq at reset", {30'd0, irq}, 32'd0);
        rd(0, 5'h00, 32'h0, "R1 control at reset");
        rd(0, 5'h04, 32'h0, "R1 counter low at reset");
        rd(1, 5'h08, 32'h0, "R1 counter high at reset");
        rd(0, 5'h0C, 32'hFFFF_FFFF, "R1 core0 compare low at reset");
        rd(1, 5'h10, 32'hFFFF_FFFF, "R1 core1 compare high at reset");
        // R2 unmapped offsets
        wr(0, 5'h14, 32'h3);
        rd(0, 5'h14, 32'h0, "R2 unmapped 0x14 reads zero");
        rd(1, 5'h1C, 32'h0, "R2 unmapped 0x1C reads zero");
        rd(0, 5'h00, 32'h0, "R2 unmapped write leaves control");
        // R9 half writes
        wr(0, 5'h04, 32'hFFFF_FFFF);
        wr(0, 5'h08, 32'h2);
        wr(0, 5'h04, 32'h0);
        rd(0, 5'h08, 32'h2, "R9 low write no borrow into high");
        wr(0, 5'h08, 32'h7);
        rd(0, 5'h04, 32'h0, "R9 high write keeps low");
        rd(0, 5'h08, 32'h7, "R9 high half written");
        // R6 shared counter
        wr(1, 5'h08, 32'h55);
        rd(0, 5'h08, 32'h55, "R6 core1 write seen by core0");
        // R7 per-core compare
        wr(1, 5'h0C, 32'h1234);
        rd(0, 5'h0C, 32'hFFFF_FFFF, "R7 core0 compare untouched");
        rd(1, 5'h0C, 32'h1234, "R7 core1 compare written");
        // R3 enable clear holds
        wr(0, 5'h04, 32'h40);
        wr(0, 5'h08, 32'h0);
        wr(0, 5'h00, 32'h2);
        idle(6);
        rd(0, 5'h04, 32'h40, "R3 counter holds when disabled");
        rd(0, 5'h00, 32'h2, "R2 control readback");
        // R4 full speed
        wr(0, 5'h00, 32'h3);
        rd(0, 5'h04, 32'h40, "R4 full-speed step 0");
        rd(0, 5'h04, 32'h41, "R4 full-speed step 1");
        rd(1, 5'h04, 32'h42, "R4 full-speed step 2");
        // R11 write beats step
        wr(0, 5'h04, 32'h100);
        rd(0, 5'h04, 32'h100, "R11 written value without increment");
        rd(0, 5'h04, 32'h101, "R11 resumes counting");
        // R10 carry
        wr(0, 5'h00, 32'h0);
        wr(0, 5'h04, 32'hFFFF_FFFE);
        wr(0, 5'h08, 32'h5);
        wr(0, 5'h00, 32'h3);
        rd(0, 5'h04, 32'hFFFF_FFFE, "R10 low before carry");
        rd(0, 5'h08, 32'h5, "R10 high before carry");
        rd(0, 5'h08, 32'h6, "R10 high after carry");
        rd(0, 5'h04, 32'h1, "R10 low after carry");
        // R5 tick mode
        wr(0, 5'h00, 32'h0);
        wr(0, 5'h04, 32'h0);
        wr(0, 5'h08, 32'h0);
        wr(0, 5'h00, 32'h1);
        idle(5);
        rd(0, 5'h04, 32'h0, "R5 no tick no count");
        pulse(); pulse(); pulse();
        rd(0, 5'h04, 32'h3, "R5 three ticks three counts");
        // R8 interrupt level, enable off
        wr(0, 5'h00, 32'h0);
        wr(0, 5'h04, 32'h10);
        wr(0, 5'h10, 32'h0);
        wr(0, 5'h0C, 32'h20);
        idle(2);
        check("R8 irq low below compare", {30'd0, irq}, 32'd0);
        wr(1, 5'h04, 32'h20);
        idle(1);
        check("R8 irq0 one-cycle latency", {31'd0, irq[0]}, 32'd0);
        idle(1);
        check("R8 irq0 high at equal, enable off", {30'd0, irq}, 32'd1);
        wr(0, 5'h10, 32'h1);
        idle(1);
        check("R8 irq0 holds one cycle", {31'd0, irq[0]}, 32'd1);
        idle(1);
        check("R8 irq0 drops after compare raised", {30'd0, irq}, 32'd0);
        wr(1, 5'h10, 32'h0);
        wr(0, 5'h04, 32'h2000);
        idle(2);
        check("R8 irq1 high above compare", {30'd0, irq}, 32'd2);
        idle(4);
        check("R12 all reads returned", exp_q.size(), 32'd0);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule